// File: doc/BRIEF.md
# I2C Slave Address Acknowledge Decision Unit

This block sits behind the bit-level receiver of an I2C slave port and decides, one received address byte at a time, whether the slave acknowledges. The receiver strobes each assembled byte in and raises a separate strobe on every start or repeated start. The block compares the byte against a configured own address of 7 or 10 bits. Any address bit can be marked as don't-care by a mask. A fixed set of protocol-reserved codes is refused whatever the mask says. The general-call code is accepted only when enabled.

One clock after each byte that the block evaluates, it pulses `ack_valid_o` and gives the decision on `ack_o`. It also keeps three flags: own address fully matched, latched read/write bit, and general call received. These hold until the next start. In 10-bit mode the decision takes two bytes. The first byte carries a fixed prefix plus the two top address bits. The second byte carries the low eight bits. A strict-compare input turns the mask off so that an exact comparison is used.

Top module: `addr_ack_filter`

## Requirements
- R1: For every address byte the block evaluates, `ack_valid_o` is high for exactly the one cycle after the `byte_valid_i` strobe, and `ack_o` carries the decision (1 = acknowledge). `ack_o` is 0 whenever `ack_valid_o` is 0.
- R2: In 7-bit mode, byte bit 0 is R/W and bits 7:1 are the address. The byte matches when each of bits 7:1 equals `own_addr_i[6:0]` or has its `mask_i[6:0]` bit set. A match acknowledges, sets `matched_o` and latches bit 0 into `rw_o`. A miss is not acknowledged.
- R3: While `exact_i` is 1 the mask has no effect and every address bit must equal the own address.
- R4: Bytes whose top four bits are 0000 (other than 0x00), and bytes whose top five bits are 11111, are never acknowledged in either mode, whatever the mask and own address.
- R5: Byte 0x00 is the general call. It is acknowledged only when `gc_en_i` is 1, and it then sets `gcall_o`. It never sets `matched_o`.
- R6: In 7-bit mode a byte whose top five bits are 11110 is never acknowledged, even with a mask of all ones.
- R7: In 10-bit mode the first byte must be 11110, A9, A8, R/W, with A9..A8 compared against `own_addr_i[9:8]` under `mask_i[9:8]`. A match acknowledges and latches R/W but leaves `matched_o` at 0. The next byte is compared against `own_addr_i[7:0]` under `mask_i[7:0]`. Only if it matches too is that byte acknowledged and `matched_o` set.
- R8: In 10-bit mode a first byte that does not match is not acknowledged. Later bytes produce no `ack_valid_o` pulse until the next start.
- R9: Once a transfer is decided (7-bit byte, general call, reserved code or 10-bit second byte), later bytes produce no `ack_valid_o` pulse and leave all flags unchanged until a start.
- R10: A `start_i` strobe clears `matched_o`, `rw_o` and `gcall_o` on the next edge and returns the block to expecting a first byte. A byte strobed in the same cycle as a start is discarded and gives no `ack_valid_o` pulse.
- R11: After reset all outputs are 0 and the block expects a first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe on start or repeated start |
| byte_valid_i | input | 1 | One-cycle strobe: `byte_i` holds a received byte |
| byte_i | input | 8 | Received byte, bit 0 is R/W on a first byte |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| exact_i | input | 1 | 1 disables masking (strict compare) |
| gc_en_i | input | 1 | 1 allows the general call to be acknowledged |
| own_addr_i | input | 10 | Own address; bits 6:0 used in 7-bit mode |
| mask_i | input | 10 | Don't-care mask, 1 = ignore that address bit |
| ack_valid_o | output | 1 | Pulse: a decision is on `ack_o` |
| ack_o | output | 1 | 1 = acknowledge, 0 = not acknowledged |
| matched_o | output | 1 | Own address fully matched since last start |
| rw_o | output | 1 | Latched R/W bit of the matching first byte |
| gcall_o | output | 1 | General call acknowledged since last start |

## Verification
The hardest case to reach is the clash between the mask and the reserved list. The own address and the mask must both be chosen so that the masked comparison alone would accept a reserved or prefix code, and only the exclusion logic then refuses it. The stimulus sets masks of all ones and own addresses next to the reserved ranges, and then walks the boundary codes of each reserved range. It does this in 7-bit mode and as a first byte in 10-bit mode. A second hard case is the two-byte 10-bit sequence with a first-byte miss. Here the stimulus sends a correct low byte right after the miss and checks that no decision pulse appears.

// File: rtl/addr_match_pkg.sv
package addr_match_pkg;

   // progress of one addressed transfer
   typedef enum logic [1:0] {
      PH_FIRST  = 2'd0,
      PH_SECOND = 2'd1,
      PH_DONE   = 2'd2
   } phase_e;

   // fixed upper bits of the first byte of a 10-bit address
   localparam logic [4:0] HI10_PREFIX = 5'b11110;
   // top bits of the reserved block at the high end of the address space
   localparam logic [4:0] HI_RESERVED = 5'b11111;
   // width of the prefix field
   localparam int unsigned PREFIX_W = 5;

endpackage

// File: rtl/masked_cmp.sv
module masked_cmp #(
   parameter int unsigned W       = 7,
   parameter bit          MASK_EN = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] dc_i,
   input  logic         dc_on_i,
   output logic         eq_o
);

   logic [W-1:0] diff;

   generate
      if (W < 1) begin : g_bad_w
         $error("masked_cmp: W must be at least 1");
      end

      if (MASK_EN) begin : g_masked
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign diff[i] = (a_i[i] ^ b_i[i]) & ~(dc_on_i & dc_i[i]);
         end
      end else begin : g_exact
         logic unused_dc;
         assign unused_dc = ^{dc_i, dc_on_i};
         assign diff      = a_i ^ b_i;
      end
   endgenerate

   assign eq_o = ~|diff;

endmodule

// File: rtl/byte_classify.sv
module byte_classify
   import addr_match_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] byte_i,
   output logic              is_gcall_o,
   output logic              is_reserved_o,
   output logic              is_hi10_o
);

   localparam int unsigned LOW_ZERO_W = BYTE_W - 4;

   logic low_block;
   logic high_block;

   generate
      if (BYTE_W != 8) begin : g_bad_w
         $error("byte_classify: address bytes are 8 bits wide");
      end
   endgenerate

   // 0x01..0x0F: start byte, bus-compatibility, spare and high-speed codes
   assign low_block     = (byte_i[BYTE_W-1 -: 4] == 4'b0000) && (byte_i[LOW_ZERO_W-1:0] != '0);
   assign high_block    = (byte_i[BYTE_W-1 -: PREFIX_W] == HI_RESERVED);
   assign is_gcall_o    = (byte_i == '0);
   assign is_reserved_o = low_block | high_block;
   assign is_hi10_o     = (byte_i[BYTE_W-1 -: PREFIX_W] == HI10_PREFIX);

endmodule

// File: rtl/addr_ack_filter.sv
module addr_ack_filter
   import addr_match_pkg::*;
#(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned ADDR_W  = 10,
   parameter bit          MASK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              byte_valid_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              ten_bit_i,
   input  logic              exact_i,
   input  logic              gc_en_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic [ADDR_W-1:0] mask_i,
   output logic              ack_valid_o,
   output logic              ack_o,
   output logic              matched_o,
   output logic              rw_o,
   output logic              gcall_o
);

   localparam int unsigned SHORT_W = BYTE_W - 1;       // 7-bit address field
   localparam int unsigned HI_W    = ADDR_W - BYTE_W;  // upper bits in 10-bit mode

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("addr_ack_filter: BYTE_W must be 8");
      end
      if (HI_W + PREFIX_W + 1 != BYTE_W) begin : g_bad_addr
         $error("addr_ack_filter: ADDR_W must leave room for prefix and R/W");
      end
   endgenerate

   phase_e phase_q, phase_d;
   logic   ack_valid_q, ack_valid_d;
   logic   ack_q, ack_d;
   logic   matched_q, matched_d;
   logic   rw_q, rw_d;
   logic   gcall_q, gcall_d;

   logic   dc_on;
   logic   short_eq, hi_eq, lo_eq;
   logic   is_gc, is_res, is_hi10;
   logic   take;

   assign dc_on = ~exact_i;

   byte_classify #(.BYTE_W(BYTE_W)) u_class (
      .byte_i        (byte_i),
      .is_gcall_o    (is_gc),
      .is_reserved_o (is_res),
      .is_hi10_o     (is_hi10)
   );

   masked_cmp #(.W(SHORT_W), .MASK_EN(MASK_EN)) u_cmp_short (
      .a_i     (byte_i[BYTE_W-1:1]),
      .b_i     (own_addr_i[SHORT_W-1:0]),
      .dc_i    (mask_i[SHORT_W-1:0]),
      .dc_on_i (dc_on),
      .eq_o    (short_eq)
   );

   masked_cmp #(.W(HI_W), .MASK_EN(MASK_EN)) u_cmp_hi (
      .a_i     (byte_i[HI_W:1]),
      .b_i     (own_addr_i[ADDR_W-1:BYTE_W]),
      .dc_i    (mask_i[ADDR_W-1:BYTE_W]),
      .dc_on_i (dc_on),
      .eq_o    (hi_eq)
   );

   masked_cmp #(.W(BYTE_W), .MASK_EN(MASK_EN)) u_cmp_lo (
      .a_i     (byte_i),
      .b_i     (own_addr_i[BYTE_W-1:0]),
      .dc_i    (mask_i[BYTE_W-1:0]),
      .dc_on_i (dc_on),
      .eq_o    (lo_eq)
   );

   assign take = byte_valid_i & ~start_i & (phase_q != PH_DONE);

   always_comb begin
      phase_d     = phase_q;
      ack_valid_d = 1'b0;
      ack_d       = 1'b0;
      matched_d   = matched_q;
      rw_d        = rw_q;
      gcall_d     = gcall_q;
      if (start_i) begin
         phase_d   = PH_FIRST;
         matched_d = 1'b0;
         rw_d      = 1'b0;
         gcall_d   = 1'b0;
      end else if (take) begin
         ack_valid_d = 1'b1;
         phase_d     = PH_DONE;
         if (phase_q == PH_SECOND) begin
            ack_d     = lo_eq;
            matched_d = lo_eq;
         end else if (is_gc) begin
            ack_d   = gc_en_i;
            gcall_d = gc_en_i;
         end else if (is_res) begin
            ack_d = 1'b0;
         end else if (ten_bit_i) begin
            if (is_hi10 && hi_eq) begin
               ack_d   = 1'b1;
               rw_d    = byte_i[0];
               phase_d = PH_SECOND;
            end
         end else if (!is_hi10 && short_eq) begin
            ack_d     = 1'b1;
            matched_d = 1'b1;
            rw_d      = byte_i[0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_FIRST;
         ack_valid_q <= 1'b0;
         ack_q       <= 1'b0;
         matched_q   <= 1'b0;
         rw_q        <= 1'b0;
         gcall_q     <= 1'b0;
      end else begin
         phase_q     <= phase_d;
         ack_valid_q <= ack_valid_d;
         ack_q       <= ack_d;
         matched_q   <= matched_d;
         rw_q        <= rw_d;
         gcall_q     <= gcall_d;
      end
   end

   assign ack_valid_o = ack_valid_q;
   assign ack_o       = ack_q;
   assign matched_o   = matched_q;
   assign rw_o        = rw_q;
   assign gcall_o     = gcall_q;

   // decision pulse only follows a byte strobe that did not collide with a start
   p_pulse_after_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid_o |-> ($past(byte_valid_i) && !$past(start_i)));

   p_ack_qualified_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> ack_valid_o);

   p_reserved_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid_i && !start_i && phase_q == PH_FIRST && is_res) |=> (ack_valid_o && !ack_o));

   p_gcall_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gcall_o) |-> $past(gc_en_i));

   p_gcall_not_own_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(matched_o && gcall_o));

   p_prefix_short_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid_i && !start_i && phase_q == PH_FIRST && !ten_bit_i && is_hi10) |=> !ack_o);

   p_decided_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DONE && !start_i) |=> (!ack_valid_o && $stable(matched_o) && $stable(gcall_o)));

   p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!matched_o && !gcall_o && !rw_o && !ack_valid_o));

endmodule

// File: tb/sim_addr_ack_filter.sv
`timescale 1ns/1ps
module sim_addr_ack_filter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       st = 1'b0;
   logic       bv = 1'b0;
   logic [7:0] by = '0;
   logic       tb10 = 1'b0;
   logic       ex = 1'b0;
   logic       gce = 1'b0;
   logic [9:0] own = '0;
   logic [9:0] msk = '0;
   logic       ack_valid, ack, matched, rw, gcall;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   string cur_req = "R11";

   always #2.5 clk = ~clk;

   addr_ack_filter u0 (
      .clk(clk), .rst_n(rst_n), .start_i(st), .byte_valid_i(bv), .byte_i(by),
      .ten_bit_i(tb10), .exact_i(ex), .gc_en_i(gce), .own_addr_i(own), .mask_i(msk),
      .ack_valid_o(ack_valid), .ack_o(ack), .matched_o(matched), .rw_o(rw), .gcall_o(gcall)
   );

   // behavioural reference
   int ph = 0;
   bit m_av = 0, m_ack = 0, m_mt = 0, m_rw = 0, m_gc = 0;

   function automatic bit mm(input logic [9:0] a, input logic [9:0] b,
                             input logic [9:0] m, input int n, input bit dc);
      for (int i = 0; i < n; i++)
         if (a[i] != b[i] && !(dc && m[i])) return 1'b0;
      return 1'b1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph = 0; m_av = 0; m_ack = 0; m_mt = 0; m_rw = 0; m_gc = 0;
      end else begin
         m_av = 0; m_ack = 0;
         if (st) begin
            ph = 0; m_mt = 0; m_rw = 0; m_gc = 0;
         end else if (bv && ph != 2) begin
            m_av = 1;
            if (ph == 1) begin
               m_ack = mm({2'b0, by}, {2'b0, own[7:0]}, {2'b0, msk[7:0]}, 8, !ex);
               m_mt = m_ack; ph = 2;
            end else begin
               ph = 2;
               if (by == 8'h00) begin
                  m_ack = gce; m_gc = gce;
               end else if (by < 8'h10 || by >= 8'hF8) begin
                  m_ack = 0;
               end else if (tb10) begin
                  if (by[7:3] == 5'b11110 &&
                      mm({8'b0, by[2:1]}, {8'b0, own[9:8]}, {8'b0, msk[9:8]}, 2, !ex)) begin
                     m_ack = 1; m_rw = by[0]; ph = 1;
                  end
               end else if (by[7:3] != 5'b11110 &&
                            mm({3'b0, by[7:1]}, {3'b0, own[6:0]}, {3'b0, msk[6:0]}, 7, !ex)) begin
                  m_ack = 1; m_mt = 1; m_rw = by[0];
               end
            end
         end
      end
   end

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
      end
   endtask

   // compare against the reference on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(cur_req, "ack_valid", ack_valid, m_av);
         chk(cur_req, "ack", ack, m_ack);
         chk(cur_req, "matched", matched, m_mt);
         chk(cur_req, "rw", rw, m_rw);
         chk(cur_req, "gcall", gcall, m_gc);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         checks++; failures++;
         $display("FAIL watchdog actual=%0d expected<20000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic do_start();
      @(negedge clk); st = 1'b1;
      @(negedge clk); st = 1'b0;
   endtask

   // strobe one byte, then check the decision one clock later
   task automatic send(input logic [7:0] b, input string req, input logic exp_av, input logic exp_ack);
      @(negedge clk); bv = 1'b1; by = b;
      @(negedge clk); bv = 1'b0;
      chk(req, "decision pulse", ack_valid, exp_av);
      chk(req, "decision", ack, exp_ack);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R11", "reset ack_valid", ack_valid, 1'b0);
      chk("R11", "reset matched", matched, 1'b0);
      chk("R11", "reset gcall", gcall, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "idle rw", rw, 1'b0);

      // R2: 7-bit, own 0101010, bit 4 masked
      cur_req = "R2"; own = 10'h02A; msk = 10'h010;
      do_start();
      send(8'h54, "R2", 1, 1);
      chk("R2", "matched", matched, 1'b1);
      do_start();
      send(8'h75, "R2", 1, 1);
      chk("R2", "rw latched", rw, 1'b1);
      do_start();
      send(8'h56, "R2", 1, 0);
      chk("R2", "no match", matched, 1'b0);

      // R3: strict compare ignores mask
      cur_req = "R3"; ex = 1'b1;
      do_start();
      send(8'h75, "R3", 1, 0);
      do_start();
      send(8'h55, "R3", 1, 1);
      ex = 1'b0;

      // R4: reserved codes with a mask that would accept anything
      cur_req = "R4"; own = 10'h004; msk = 10'h3FF;
      foreach (by_list[i]) begin
         do_start();
         send(by_list[i], "R4", 1, 0);
      end
      do_start();
      send(8'h40, "R4", 1, 1);
      tb10 = 1'b1;
      do_start();
      send(8'hF9, "R4", 1, 0);
      tb10 = 1'b0;

      // R5: general call
      cur_req = "R5"; own = 10'h000; msk = 10'h000; gce = 1'b0;
      do_start();
      send(8'h00, "R5", 1, 0);
      chk("R5", "gcall off", gcall, 1'b0);
      gce = 1'b1;
      do_start();
      send(8'h00, "R5", 1, 1);
      chk("R5", "gcall on", gcall, 1'b1);
      chk("R5", "not own", matched, 1'b0);

      // R6: prefix code in 7-bit mode
      cur_req = "R6"; own = 10'h078; msk = 10'h3FF;
      do_start();
      send(8'hF0, "R6", 1, 0);
      do_start();
      send(8'hF7, "R6", 1, 0);

      // R7: 10-bit, own = 10 1011 0101
      cur_req = "R7"; tb10 = 1'b1; own = 10'h2B5; msk = 10'h000;
      do_start();
      send(8'hF5, "R7", 1, 1);
      chk("R7", "first byte not full match", matched, 1'b0);
      chk("R7", "rw latched", rw, 1'b1);
      send(8'hB5, "R7", 1, 1);
      chk("R7", "full match", matched, 1'b1);
      do_start();
      send(8'hF4, "R7", 1, 1);
      send(8'hB7, "R7", 1, 0);
      chk("R7", "low miss", matched, 1'b0);
      msk = 10'h203;
      do_start();
      send(8'hF0, "R7", 1, 1);
      send(8'hB6, "R7", 1, 1);

      // R8: first byte miss, later bytes silent
      cur_req = "R8"; msk = 10'h000;
      do_start();
      send(8'hF2, "R8", 1, 0);
      send(8'hB5, "R8", 0, 0);
      chk("R8", "stays unmatched", matched, 1'b0);

      // R9: decided 7-bit transfer ignores further bytes
      cur_req = "R9"; tb10 = 1'b0; own = 10'h02A;
      do_start();
      send(8'h54, "R9", 1, 1);
      send(8'h00, "R9", 0, 0);
      chk("R9", "matched held", matched, 1'b1);
      chk("R9", "gcall untouched", gcall, 1'b0);

      // R10: start clears, collision discards byte
      cur_req = "R10";
      @(negedge clk); st = 1'b1; bv = 1'b1; by = 8'h54;
      @(negedge clk); st = 1'b0; bv = 1'b0;
      chk("R10", "collision no pulse", ack_valid, 1'b0);
      chk("R10", "matched cleared", matched, 1'b0);
      send(8'h55, "R10", 1, 1);
      chk("R10", "rw after restart", rw, 1'b1);

      // R1: pulse is a single cycle
      cur_req = "R1";
      @(negedge clk);
      chk("R1", "pulse ended", ack_valid, 1'b0);
      chk("R1", "ack low without pulse", ack, 1'b0);

      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   logic [7:0] by_list [8] = '{8'h01, 8'h02, 8'h05, 8'h07, 8'h0F, 8'hF8, 8'hFB, 8'hFF};

endmodule